// File: doc/BRIEF.md
# Bidirectional Cascadable Row Scan Shifter

This block walks a single start pulse across a long chain of row-select outputs so that an active-matrix panel is scanned one row per shift clock. Two shared start-pulse pins swap roles with a direction input. In forward scan, pin A receives the pulse, rows advance from the first to the last, and pin B hands a carry to the next device. In reverse scan, pin B receives, rows advance from the last to the first, and pin A drives the carry. Devices can therefore be chained in either scan order.

The carry rises on the falling clock edge of the N-th shift clock, counting the capture clock as the first. It stays high for one full clock period, so the next device in the chain captures it on its following rising edge. Three active-high blanking inputs each force one interleaved group of rows to the inactive level without disturbing the shift contents. The outputs are logic-level selects. Conversion to gate-on and gate-off voltages is done outside this block.

Top module: `gate_scan_shifter`

## Requirements
- R1: With `scan_fwd_i` = 1, the level on `spa_in_i` is captured into row 1 (`row_sel_o[0]`) on a rising clock edge, and each later rising edge moves the contents one row toward row N.
- R2: With `scan_fwd_i` = 0, the level on `spb_in_i` is captured into row N (`row_sel_o[N-1]`) on a rising clock edge, and each later rising edge moves the contents one row toward row 1.
- R3: In forward scan, `spb_oe_o` = 1 and `spa_oe_o` = 0. In reverse scan, `spa_oe_o` = 1 and `spb_oe_o` = 0. Exactly one pin enable is high at any time outside reset.
- R4: After a one-clock start pulse is captured, the driving pin's output goes high at the falling edge of the N-th rising clock, counting the capture clock as 1. It stays high until the next falling edge and is low otherwise.
- R5: Blank input k (bit k of `blank_i`, k = 0..2) forces to 0 every row output whose zero-based index i satisfies i mod 3 = k. Rows are therefore grouped as 1,4,7.. / 2,5,8.. / 3,6,9... Unblanked rows show the shift contents.
- R6: Asserting `rst_n` low clears all rows and the carry at once, without a clock. After release, the first two rising edges still hold the block in reset, and the third rising edge captures normally.
- R7: The pin that is not the scan input for the current direction has no effect on the rows.
- R8: After a single one-clock start pulse, exactly one row output is high on each of the N clocks of the scan, and none are high after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_fwd_i | input | 1 | 1 = scan row 1 to N, 0 = scan row N to 1 |
| spa_in_i | input | 1 | Level seen on start-pulse pin A |
| spa_out_o | output | 1 | Value driven onto pin A (carry in reverse scan) |
| spa_oe_o | output | 1 | Tri-state enable for pin A |
| spb_in_i | input | 1 | Level seen on start-pulse pin B |
| spb_out_o | output | 1 | Value driven onto pin B (carry in forward scan) |
| spb_oe_o | output | 1 | Tri-state enable for pin B |
| blank_i | input | 3 | Active-high group blanking |
| row_sel_o | output | 256 | Row-select outputs, bit i = row i+1 |

## Verification
The carry is the hardest behaviour to reach. It only appears after a pulse has travelled the whole chain, and it is launched on the opposite clock edge from everything else. The bench therefore injects a single pulse, follows it row by row through all N clocks in each direction, and samples the carry pin one cycle before, during and after its high window. Throughout each scan, the inactive pin is held high to show that it is ignored. The blanking groups are checked on a six-row block of ones, which places every group at least twice inside a single clock period.

// File: rtl/gss_pkg.sv
package gss_pkg;
  typedef enum logic {
    SCAN_REV = 1'b0,
    SCAN_FWD = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/gss_rst_sync.sv
module gss_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[DEPTH-1];
endmodule

// File: rtl/gss_shift_chain.sv
module gss_shift_chain
  import gss_pkg::*;
#(
  parameter int unsigned N_ROWS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  scan_dir_e         dir_i,
  input  logic              sp_i,
  output logic [N_ROWS-1:0] stage_o,
  output logic              last_o
);
  localparam int unsigned LAST = N_ROWS - 1;

  logic [N_ROWS-1:0] stage_q;
  logic [N_ROWS-1:0] stage_d;
  logic              shift_en;

  assign shift_en = 1'b1;

  for (genvar i = 0; i < N_ROWS; i++) begin : g_stage
    logic from_lower;
    logic from_upper;
    if (i == 0) begin : g_lo_end
      assign from_lower = sp_i;
    end else begin : g_lo_mid
      assign from_lower = stage_q[i-1];
    end
    if (i == LAST) begin : g_hi_end
      assign from_upper = sp_i;
    end else begin : g_hi_mid
      assign from_upper = stage_q[i+1];
    end
    always_comb begin
      stage_d[i] = (dir_i == SCAN_FWD) ? from_lower : from_upper;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (shift_en) stage_q <= stage_d;
  end

  assign stage_o = stage_q;
  assign last_o  = (dir_i == SCAN_FWD) ? stage_q[LAST] : stage_q[0];
endmodule

// File: rtl/gss_carry_gen.sv
module gss_carry_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic last_i,
  output logic carry_o
);
  logic carry_q;
  logic carry_d;

  always_comb begin
    carry_d = last_i;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= carry_d;
  end

  assign carry_o = carry_q;
endmodule

// File: rtl/gss_blank_mask.sv
module gss_blank_mask #(
  parameter int unsigned N_ROWS   = 256,
  parameter int unsigned N_GROUPS = 3
) (
  input  logic [N_ROWS-1:0]   stage_i,
  input  logic [N_GROUPS-1:0] blank_i,
  output logic [N_ROWS-1:0]   row_o
);
  for (genvar i = 0; i < N_ROWS; i++) begin : g_row
    localparam int unsigned GRP = i % N_GROUPS;
    assign row_o[i] = stage_i[i] & ~blank_i[GRP];
  end
endmodule

// File: rtl/gate_scan_shifter.sv
module gate_scan_shifter
  import gss_pkg::*;
#(
  parameter int unsigned N_ROWS   = 256,
  parameter int unsigned N_GROUPS = 3,
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scan_fwd_i,
  input  logic                spa_in_i,
  output logic                spa_out_o,
  output logic                spa_oe_o,
  input  logic                spb_in_i,
  output logic                spb_out_o,
  output logic                spb_oe_o,
  input  logic [N_GROUPS-1:0] blank_i,
  output logic [N_ROWS-1:0]   row_sel_o
);
  logic              rst_sync_n;
  scan_dir_e         dir;
  logic              sp_in;
  logic [N_ROWS-1:0] stage_q;
  logic              last_stage;
  logic              carry_q;

  assign dir   = scan_dir_e'(scan_fwd_i);
  assign sp_in = (dir == SCAN_FWD) ? spa_in_i : spb_in_i;

  gss_rst_sync #(.DEPTH(SYNC_LEN)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  gss_shift_chain #(.N_ROWS(N_ROWS)) u_chain (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .dir_i   (dir),
    .sp_i    (sp_in),
    .stage_o (stage_q),
    .last_o  (last_stage)
  );

  gss_carry_gen u_carry (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .last_i  (last_stage),
    .carry_o (carry_q)
  );

  gss_blank_mask #(.N_ROWS(N_ROWS), .N_GROUPS(N_GROUPS)) u_mask (
    .stage_i (stage_q),
    .blank_i (blank_i),
    .row_o   (row_sel_o)
  );

  assign spa_oe_o  = (dir == SCAN_REV);
  assign spb_oe_o  = (dir == SCAN_FWD);
  assign spa_out_o = spa_oe_o & carry_q;
  assign spb_out_o = spb_oe_o & carry_q;
endmodule

// File: rtl/gss_checker.sv
module gss_checker #(
  parameter int unsigned N_ROWS   = 256,
  parameter int unsigned N_GROUPS = 3
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                scan_fwd_i,
  input logic                spa_in_i,
  input logic                spb_in_i,
  input logic                spa_oe_o,
  input logic                spb_oe_o,
  input logic                spb_out_o,
  input logic [N_GROUPS-1:0] blank_i,
  input logic [N_ROWS-1:0]   stage_q,
  input logic [N_ROWS-1:0]   row_sel_o
);
  AST_FWD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    scan_fwd_i |=> (stage_q[0] == $past(spa_in_i))); // R1

  AST_FWD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    scan_fwd_i |=> (stage_q[1] == $past(stage_q[0]))); // R1

  AST_REV_CAPTURE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !scan_fwd_i |=> (stage_q[N_ROWS-1] == $past(spb_in_i))); // R2

  AST_PIN_ROLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones({spa_oe_o, spb_oe_o}) == 1); // R3

  AST_CARRY_FOLLOW: assert property (@(negedge clk) disable iff (!rst_sync_n)
    scan_fwd_i |=> (!scan_fwd_i || spb_out_o == $past(stage_q[N_ROWS-1]))); // R4

  AST_BLANK_GROUP0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    blank_i[0] |-> !row_sel_o[0]); // R5

  AST_UNBLANKED_PASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (blank_i == '0) |-> (row_sel_o == stage_q)); // R5
endmodule

bind gate_scan_shifter gss_checker #(.N_ROWS(N_ROWS), .N_GROUPS(N_GROUPS)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .scan_fwd_i (scan_fwd_i),
  .spa_in_i   (spa_in_i),
  .spb_in_i   (spb_in_i),
  .spa_oe_o   (spa_oe_o),
  .spb_oe_o   (spb_oe_o),
  .spb_out_o  (spb_out_o),
  .blank_i    (blank_i),
  .stage_q    (stage_q),
  .row_sel_o  (row_sel_o)
);

// File: tb/tb_gate_scan_shifter.sv
module tb_gate_scan_shifter;
  localparam int unsigned N        = 256;
  localparam int unsigned G        = 3;
  localparam time         CLK_PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic         scan_fwd_i;
  logic         spa_in_i, spb_in_i;
  logic         spa_out_o, spa_oe_o, spb_out_o, spb_oe_o;
  logic [G-1:0] blank_i;
  logic [N-1:0] row_sel_o;

  int checks;
  int errors;
  bit done;

  gate_scan_shifter #(.N_ROWS(N), .N_GROUPS(G)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_fwd_i (scan_fwd_i),
    .spa_in_i   (spa_in_i),
    .spa_out_o  (spa_out_o),
    .spa_oe_o   (spa_oe_o),
    .spb_in_i   (spb_in_i),
    .spb_out_o  (spb_out_o),
    .spb_oe_o   (spb_oe_o),
    .blank_i    (blank_i),
    .row_sel_o  (row_sel_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_vec(string req, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_bit(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // R6: reset state, async clear and synchronised release
  task automatic test_reset();
    logic [N-1:0] exp;
    check_vec("R6 reset rows", row_sel_o, '0);
    check_bit("R6 reset carry A", spa_out_o, 1'b0);
    check_bit("R6 reset carry B", spb_out_o, 1'b0);
    rst_n = 1'b1;
    tick();
    tick();
    scan_fwd_i = 1'b1;
    spa_in_i   = 1'b1;
    tick();
    exp = '0; exp[0] = 1'b1;
    check_vec("R6 first capture after release", row_sel_o, exp);
    tick();
    tick();
    spa_in_i = 1'b0;
    #2 rst_n = 1'b0;
    #1 check_vec("R6 async clear", row_sel_o, '0);
    tick();
    check_vec("R6 held in reset", row_sel_o, '0);
    rst_n = 1'b1;
    spa_in_i = 1'b0;
    tick();
    tick();
    check_vec("R6 idle after release", row_sel_o, '0);
  endtask

  // R1 R2 R3 R4 R7 R8: one pulse through the whole chain
  task automatic test_scan(bit fwd);
    logic [N-1:0] exp;
    string tag;
    tag = fwd ? "R1" : "R2";
    scan_fwd_i = fwd;
    spa_in_i   = fwd ? 1'b0 : 1'b1;   // inactive pin held high (R7)
    spb_in_i   = fwd ? 1'b1 : 1'b0;
    #1;
    check_bit("R3 pin A enable", spa_oe_o, !fwd);
    check_bit("R3 pin B enable", spb_oe_o, fwd);
    tick();
    tick();
    check_vec("R7 inactive pin ignored", row_sel_o, '0);
    if (fwd) spa_in_i = 1'b1; else spb_in_i = 1'b1;
    tick();
    if (fwd) spa_in_i = 1'b0; else spb_in_i = 1'b0;
    for (int k = 1; k <= N; k++) begin
      exp = '0;
      exp[fwd ? (k-1) : (N-k)] = 1'b1;
      check_vec(tag, row_sel_o, exp);
      check_bit("R8 single active row", ($countones(row_sel_o) == 1), 1'b1);
      check_bit("R4 carry low during scan", fwd ? spb_out_o : spa_out_o, 1'b0);
      if (k < N) tick();
    end
    #(CLK_PERIOD/2);
    check_bit("R4 carry rises at falling edge of clock N", fwd ? spb_out_o : spa_out_o, 1'b1);
    check_bit("R4 input pin not driven", fwd ? spa_out_o : spb_out_o, 1'b0);
    tick();
    check_vec("R8 rows clear after scan", row_sel_o, '0);
    check_bit("R4 carry held one period", fwd ? spb_out_o : spa_out_o, 1'b1);
    tick();
    check_bit("R4 carry low after one period", fwd ? spb_out_o : spa_out_o, 1'b0);
    spa_in_i = 1'b0;
    spb_in_i = 1'b0;
  endtask

  // R5: blanking groups over a block of six ones
  task automatic test_blank();
    logic [N-1:0] exp;
    scan_fwd_i = 1'b1;
    spa_in_i   = 1'b1;
    for (int k = 0; k < 6; k++) tick();
    spa_in_i = 1'b0;
    for (int b = 0; b < 8; b++) begin
      blank_i = b[G-1:0];
      #1;
      exp = '0;
      for (int i = 0; i < 6; i++) exp[i] = !blank_i[i % G];
      check_vec($sformatf("R5 blank=%0d", b), row_sel_o, exp);
    end
    blank_i = '0;
    for (int k = 0; k < N + 2; k++) tick();
    check_vec("R5 flushed", row_sel_o, '0);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; scan_fwd_i = 1'b1;
    spa_in_i = 1'b0; spb_in_i = 1'b0; blank_i = '0;
    tick();
    tick();
    test_reset();
    test_scan(1'b1);
    test_scan(1'b0);
    test_blank();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule